// File: doc/BRIEF.md
# Monitor Sense-Line Sequencer

This block identifies an attached display by probing three open-drain sense lines. A one-cycle start request launches a fixed probe sequence. First all three lines are driven high for a short precharge interval. Next the drivers are released and the lines are left to settle. After that, each line in turn is pulled low while the other two float. At the end of the release phase and at the end of each pull-low phase, the floating lines are sampled. The samples are packed into an 11-bit sense code. A one-cycle done pulse marks the point at which the code is complete.

The line drivers are controlled by a 6-bit word. Bits 2:0 hold the level each line is driven to. Bits 5:3 hold a per-line driver-off flag, where 1 means the line floats. The line levels come back on a 3-bit input. The settle interval is a cycle count supplied at start. Turning the finished code into a display mode is left to the logic that consumes it.

Top module: `msense_seq`

## Requirements
- R1: After reset, `drv_ctl` is 6'b111111 (all lines released, driven value 1), `code` is 0, and `done` and `busy` are 0.
- R2: On the cycle after an accepted `start`, `drv_ctl` becomes 6'b000111 (all drivers on, all driven high). It keeps this value for `PRE_CYC` cycles.
- R3: Next comes the release phase: `drv_ctl` = 6'b111111 for S settle cycles. On its last cycle the three line levels are captured into `code[10:8]`, with line 2 in bit 10 and line 0 in bit 8.
- R4: Next, line 2 is pulled low with `drv_ctl` = 6'b011011 for S cycles. On the last cycle, line 1 is captured into `code[5]` and line 0 into `code[4]`.
- R5: Next, line 1 is pulled low with `drv_ctl` = 6'b101101 for S cycles. On the last cycle, line 2 is captured into `code[3]` and line 0 into `code[2]`.
- R6: Next, line 0 is pulled low with `drv_ctl` = 6'b110110 for S cycles. On the last cycle, line 2 is captured into `code[1]` and line 1 into `code[0]`.
- R7: `code[7:6]` is always 0.
- R8: `done` is high for exactly one cycle. It rises `PRE_CYC + 4*S` clock edges after the edge that accepted `start`. At that point and afterwards `drv_ctl` is 6'b111111. `busy` is high from the cycle after acceptance through the `done` cycle. `code` holds its value until the next accepted start, which clears it.
- R9: A `start` raised while `busy` is high is ignored. Sequence timing and result are unchanged.
- R10: S is taken from `settle_cyc` on the accepting edge, and a value of 0 is treated as 1. Later changes to `settle_cyc` during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a probe sequence |
| settle_cyc | input | CW | Settle interval in cycles for the release and pull-low phases |
| sense_in | input | 3 | Levels read back from sense lines 2..0 |
| drv_ctl | output | 6 | Driver-off flags [5:3] and driven levels [2:0] for lines 2..0 |
| code | output | 11 | Packed sense code |
| done | output | 1 | One-cycle pulse when the code is complete |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench models a display that has a per-line pull level plus a random matrix of line-to-line links. A pulled-low line drags down any line linked to it, so every probe phase yields a different pattern. This separates a mis-routed or swapped code bit from a correct one.

Directed profiles cover the remaining cases: all lines high with no links, all lines grounded, and fully cross-linked lines. A settle value of 0 checks the minimum-length phases. The drive word is compared on every cycle of every phase, which exposes a phase that is one cycle too long or too short. Separate runs raise `start` in mid-sequence and change `settle_cyc` in mid-sequence, and those runs must complete with exactly the same timing and code as an undisturbed run.

// File: rtl/msense_pkg.sv
`timescale 1ns/1ps
package msense_pkg;

  localparam int LINES  = 3;
  localparam int CODE_W = 11;
  localparam int CTL_W  = 2 * LINES;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_REL,
    PH_LO2,
    PH_LO1,
    PH_LO0,
    PH_DONE
  } phase_e;

  // Driver word per phase: {off[2:0], level[2:0]}; off=1 leaves the line floating.
  function automatic logic [CTL_W-1:0] drive_word(input phase_e ph);
    logic [CTL_W-1:0] w;
    case (ph)
      PH_PRE:  w = 6'b000_111;
      PH_LO2:  w = 6'b011_011;
      PH_LO1:  w = 6'b101_101;
      PH_LO0:  w = 6'b110_110;
      default: w = 6'b111_111;
    endcase
    return w;
  endfunction

  // Merge the sampled line levels into the code field owned by the phase.
  function automatic logic [CODE_W-1:0] fold_sample(input phase_e ph,
                                                    input logic [CODE_W-1:0] cur,
                                                    input logic [LINES-1:0] lv);
    logic [CODE_W-1:0] nxt;
    nxt = cur;
    case (ph)
      PH_REL: nxt[10:8] = lv;
      PH_LO2: nxt[5:4]  = {lv[1], lv[0]};
      PH_LO1: nxt[3:2]  = {lv[2], lv[0]};
      PH_LO0: nxt[1:0]  = {lv[2], lv[1]};
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic is_sample_phase(input phase_e ph);
    return (ph == PH_REL) || (ph == PH_LO2) || (ph == PH_LO1) || (ph == PH_LO0);
  endfunction

endpackage

// File: rtl/msense_timer.sv
`timescale 1ns/1ps
module msense_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - CW'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign expire = (cnt == '0);

  // R10: a running interval shrinks by exactly one per cycle
  p_timer_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

  // R10: loaded intervals are never zero length
  p_timer_load_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/msense_fsm.sv
`timescale 1ns/1ps
module msense_fsm
  import msense_pkg::*;
#(
  parameter int CW      = 16,
  parameter int PRE_CYC = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] settle_cyc,
  input  logic          expire,
  output phase_e        phase,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          accept,
  output logic          capture
);

  localparam int PRE_EFF = (PRE_CYC < 1) ? 1 : PRE_CYC;
  localparam logic [CW-1:0] PRE_LD = CW'(PRE_EFF);

  phase_e        nxt;
  logic [CW-1:0] settle_q;
  logic [CW-1:0] settle_eff;

  assign settle_eff = (settle_cyc == '0) ? CW'(1) : settle_cyc;
  assign accept     = start && (phase == PH_IDLE);
  assign capture    = expire && is_sample_phase(phase);

  always_comb begin
    nxt      = phase;
    load     = 1'b0;
    load_val = settle_q;
    case (phase)
      PH_IDLE: if (start) begin
        nxt = PH_PRE; load = 1'b1; load_val = PRE_LD;
      end
      PH_PRE:  if (expire) begin nxt = PH_REL; load = 1'b1; end
      PH_REL:  if (expire) begin nxt = PH_LO2; load = 1'b1; end
      PH_LO2:  if (expire) begin nxt = PH_LO1; load = 1'b1; end
      PH_LO1:  if (expire) begin nxt = PH_LO0; load = 1'b1; end
      PH_LO0:  if (expire) nxt = PH_DONE;
      PH_DONE: nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      settle_q <= CW'(1);
    end else begin
      phase <= nxt;
      if (accept) settle_q <= settle_eff;
    end
  end

  // R9: precharge is entered only from idle
  p_pre_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_PRE) |=> (phase != PH_PRE));

  // R10: the latched settle value stays put while a sequence runs
  p_settle_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(settle_q));

  // R8: the done phase lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |=> (phase == PH_IDLE));

endmodule

// File: rtl/msense_capture.sv
`timescale 1ns/1ps
module msense_capture
  import msense_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  phase_e            phase,
  input  logic [LINES-1:0]  lines,
  output logic [CODE_W-1:0] code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (clear) begin
      code <= '0;
    end else if (capture) begin
      code <= fold_sample(phase, code, lines);
    end
  end

  // R7: the unused code bits stay clear
  p_gap_bits_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    code[7:6] == 2'b00);

  // R8: outside clear and capture the code holds
  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !capture) |=> $stable(code));

endmodule

// File: rtl/msense_seq.sv
`timescale 1ns/1ps
module msense_seq
  import msense_pkg::*;
#(
  parameter int CW      = 16,
  parameter int PRE_CYC = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] settle_cyc,
  input  logic [2:0]    sense_in,
  output logic [5:0]    drv_ctl,
  output logic [10:0]   code,
  output logic          done,
  output logic          busy
);

  phase_e        phase;
  logic          load;
  logic [CW-1:0] load_val;
  logic          expire;
  logic          accept;
  logic          capture;
  logic [2:0]    pull_low;

  msense_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expire   (expire)
  );

  msense_fsm #(.CW(CW), .PRE_CYC(PRE_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .settle_cyc (settle_cyc),
    .expire     (expire),
    .phase      (phase),
    .load       (load),
    .load_val   (load_val),
    .accept     (accept),
    .capture    (capture)
  );

  msense_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (capture),
    .phase   (phase),
    .lines   (sense_in),
    .code    (code)
  );

  assign drv_ctl  = drive_word(phase);
  assign done     = (phase == PH_DONE);
  assign busy     = (phase != PH_IDLE);
  assign pull_low = ~drv_ctl[5:3] & ~drv_ctl[2:0];

  // R4: never more than one line pulled low at a time
  p_single_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pull_low) <= 1);

  // R8: drivers are released while done is shown
  p_released_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (drv_ctl == 6'b111111));

  // R8: done never lasts two cycles
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a start while busy never restarts the sequence
  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: tb/msense_seq_tb.sv
`timescale 1ns/1ps
module msense_seq_tb;

  localparam int CW  = 16;
  localparam int PRE = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] settle_cyc = '0;
  logic [2:0]    sense_in;
  logic [5:0]    drv_ctl;
  logic [10:0]   code;
  logic          done;
  logic          busy;

  logic [2:0] pull = 3'b111;
  logic [8:0] link = '0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  msense_seq #(.CW(CW), .PRE_CYC(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cyc(settle_cyc),
    .sense_in(sense_in), .drv_ctl(drv_ctl), .code(code), .done(done), .busy(busy)
  );

  // Display model: driven lines show their level; floating lines show the pull
  // level unless a linked line is being pulled low.
  function automatic logic [2:0] levels(input logic [5:0] ctl, input logic [2:0] pu,
                                        input logic [8:0] lk);
    logic [2:0] lv;
    for (int i = 0; i < 3; i++) begin
      if (!ctl[3+i]) lv[i] = ctl[i];
      else begin
        lv[i] = pu[i];
        for (int j = 0; j < 3; j++)
          if (!ctl[3+j] && !ctl[j] && lk[i*3+j]) lv[i] = 1'b0;
      end
    end
    return lv;
  endfunction

  always_comb sense_in = levels(drv_ctl, pull, link);

  function automatic logic [10:0] want_code(input logic [2:0] pu, input logic [8:0] lk);
    logic [2:0] r, a, b, c;
    r = levels(6'b111111, pu, lk);
    a = levels(6'b011011, pu, lk);
    b = levels(6'b101101, pu, lk);
    c = levels(6'b110110, pu, lk);
    return {r, 2'b00, a[1], a[0], b[2], b[0], c[2], c[1]};
  endfunction

  // phase index for cycle k after the accepting edge: 0 pre,1 rel,2..4 pulls,5 done,6 idle
  function automatic int phase_at(input int k, input int s);
    if (k < PRE) return 0;
    if (k < PRE + s) return 1;
    if (k < PRE + 2*s) return 2;
    if (k < PRE + 3*s) return 3;
    if (k < PRE + 4*s) return 4;
    if (k == PRE + 4*s) return 5;
    return 6;
  endfunction

  function automatic logic [5:0] want_ctl(input int ph);
    case (ph)
      0: return 6'b000111;
      2: return 6'b011011;
      3: return 6'b101101;
      4: return 6'b110110;
      default: return 6'b111111;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int sv, input logic [2:0] pu, input logic [8:0] lk,
                     input bit poke, input bit twiddle);
    int s, last, mis[6], first_bad[6], done_k, busy_bad;
    logic [10:0] exp_c, held;
    s = (sv == 0) ? 1 : sv;
    last = PRE + 4*s;
    pull = pu; link = lk;
    exp_c = want_code(pu, lk);
    for (int i = 0; i < 6; i++) begin mis[i] = 0; first_bad[i] = 0; end
    done_k = -1; busy_bad = 0;
    @(negedge clk); settle_cyc = CW'(sv); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    for (int k = 0; k <= last + 2; k++) begin
      int ph;
      ph = phase_at(k, s);
      if (drv_ctl !== want_ctl(ph)) begin
        if (mis[ph] == 0) first_bad[ph] = int'(drv_ctl);
        mis[ph]++;
      end
      if (done) begin
        if (done_k == -1) done_k = k; else done_k = -2;
      end
      if (busy !== (k <= last)) busy_bad++;
      if (twiddle && k == 3) settle_cyc = CW'($urandom_range(40, 2));
      if (poke && (k == PRE + 1 || k == PRE + s + 1)) start = 1'b1;
      else start = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    start = 1'b0;
    check(mis[0] == 0, "R2 precharge drive", first_bad[0], 6'b000111);
    check(mis[1] == 0, "R3 release drive", first_bad[1], 6'b111111);
    check(mis[2] == 0, "R4 line2 low drive", first_bad[2], 6'b011011);
    check(mis[3] == 0, "R5 line1 low drive", first_bad[3], 6'b101101);
    check(mis[4] == 0, "R6 line0 low drive", first_bad[4], 6'b110110);
    check(mis[5] == 0 && mis[6-1] == 0, "R8 drive at done", first_bad[5], 6'b111111);
    check(done_k == last, "R8 done timing", done_k, last);
    check(busy_bad == 0, "R8 busy window", busy_bad, 0);
    check(code[10:8] == exp_c[10:8], "R3 code[10:8]", code[10:8], exp_c[10:8]);
    check(code[5:4] == exp_c[5:4], "R4 code[5:4]", code[5:4], exp_c[5:4]);
    check(code[3:2] == exp_c[3:2], "R5 code[3:2]", code[3:2], exp_c[3:2]);
    check(code[1:0] == exp_c[1:0], "R6 code[1:0]", code[1:0], exp_c[1:0]);
    check(code[7:6] == 2'b00, "R7 gap bits", code[7:6], 0);
    if (poke) check(code == exp_c && done_k == last, "R9 start while busy", code, exp_c);
    if (twiddle || sv == 0) check(done_k == last, "R10 settle latch", done_k, last);
    held = code;
    pull = ~pu;
    repeat (4) @(negedge clk);
    check(code == held && drv_ctl == 6'b111111, "R8 code holds when idle", code, held);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(drv_ctl == 6'b111111, "R1 reset drive", drv_ctl, 6'b111111);
    check(code == 11'd0, "R1 reset code", code, 0);
    check(!done && !busy, "R1 reset flags", {done, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(drv_ctl == 6'b111111 && !busy, "R1 idle after reset", drv_ctl, 6'b111111);

    run(1, 3'b111, 9'd0, 1'b0, 1'b0);
    run(0, 3'b111, 9'd0, 1'b0, 1'b0);
    run(5, 3'b000, 9'd0, 1'b0, 1'b0);
    run(3, 3'b111, 9'h1ff, 1'b0, 1'b0);
    run(7, 3'b101, 9'b000_001_100, 1'b1, 1'b0);
    run(9, 3'b011, 9'b010_100_001, 1'b0, 1'b1);
    for (int n = 0; n < 12; n++)
      run(int'($urandom_range(25, 0)), 3'($urandom), 9'($urandom), n[0], n[1]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule